// File: doc/BRIEF.md
# Display Transmitter Configuration Register Slave

This block gives a host controller access to the configuration and status registers of a digital display transmitter over a two-wire serial bus. It oversamples the serial clock and data lines with the chip's system clock, recognises START and STOP conditions, and answers to a 7-bit device address whose upper four bits are fixed at `0111` and whose lower three bits come from strap pins. Each transfer moves exactly one byte: a write names a sub-address and one data byte, and a read names the sub-address in a write phase, then issues a repeated START and reads one byte back.

The register space holds fixed identity and frequency-limit bytes, read/write mode fields that drive the transmitter (power-up, latch edge, bus width, dual-edge latching, sync enables, monitor-sense source, de-skew step and enable, and a tuning byte that must hold 89h for normal operation), and read-only views of status inputs. The active-low asynchronous reset returns the serial engine to idle, forces the power-up bit and the monitor-sense select to zero, and leaves every other register as it was.

Top module: `dvi_cfg_regs`

## Requirements
- R1: The slave acknowledges a device address byte only when its upper seven bits equal `0111` followed by `dev_pins[2:1:0]`; for any other address it never pulls SDA low and its registers stay unchanged.
- R2: While `rst_n` is low, `pwr_on` (bit 0 of sub-address 08h) reads 0 and `mon_sel` (bits 2:0 of sub-address 09h) reads 000.
- R3: Through and after a reset pulse, the edge, width, dual-edge, sync-enable, de-skew and tuning fields keep the values last written.
- R4: Reads of sub-addresses 00h, 01h, 02h, 03h, 04h, 06h and 07h return 01h, 00h, 06h, 00h, 00h, 19h and 64h.
- R5: A single-byte write updates the outputs: 08h bit0 `pwr_on`, bit1 `edge_rise`, bit2 `wide_bus`, bit3 `dual_edge`, bit4 `hs_en`, bit5 `vs_en`; 09h bits 2:0 `mon_sel`; 0Ah bits 2:0 `dsk_step`, bit3 `dsk_en`; 0Ch all bits `tune_byte`.
- R6: A single-byte read returns the register MSB first; 09h carries `hot_plug` at bit4, `rx_sense` at bit5, `vref_low` at bit6; 0Ah carries `gp_in` at bits 6:4; 0Bh returns `cfg_in`; unused bits read 0.
- R7: Only the first data byte of a write is acknowledged and stored; later bytes get no acknowledge and no effect. After one read byte the slave releases SDA, so further read clocks see FFh.
- R8: Writes to read-only or unmapped sub-addresses are acknowledged and change nothing; reads of unmapped sub-addresses return 00h.
- R9: The slave changes its SDA drive only while SCL is low.
- R10: The mode outputs change only in reaction to a write to their own sub-address or to reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low (open drain) |
| dev_pins | input | 3 | Low three bits of the device address |
| hot_plug | input | 1 | Hot-plug status level |
| rx_sense | input | 1 | Receiver-present status level |
| vref_low | input | 1 | Low-swing input indication |
| gp_in | input | 3 | General purpose status inputs |
| cfg_in | input | 8 | User configuration byte from the pixel bus |
| pwr_on | output | 1 | 1 = transmitter powered, 0 = powered down |
| edge_rise | output | 1 | Latch edge select, 1 = rising first |
| wide_bus | output | 1 | 1 = 24-bit input, 0 = 12-bit input |
| dual_edge | output | 1 | 1 = latch on both clock edges |
| hs_en | output | 1 | Horizontal sync pass-through enable |
| vs_en | output | 1 | Vertical sync pass-through enable |
| mon_sel | output | 3 | Monitor-sense output source select |
| dsk_step | output | 3 | De-skew step setting |
| dsk_en | output | 1 | De-skew setting from register enable |
| tune_byte | output | 8 | Tuning byte, 89h for normal operation |

## Verification
The assertions assume a well-formed bus: the master changes SDA only while SCL is low except to form START and STOP, never issues STOP while the slave is driving, and holds each SCL phase for several system clocks so the two-stage synchronisers see every level. The stimulus keeps to this with a quarter-bit of six clocks, a full START, sub-address, optional repeated START and STOP around every access, and reset pulses that span several clock edges with the bus idle. Address mismatches, extra write bytes and extra read clocks are driven through the same well-formed bit timing.

// File: rtl/dvi_cfg_pkg.sv
package dvi_cfg_pkg;
  localparam int SUBW = 8;
  localparam logic [3:0] DEV_PREFIX = 4'b0111;
  localparam logic [SUBW-1:0] SA_VEN_LO = 8'h00;
  localparam logic [SUBW-1:0] SA_VEN_HI = 8'h01;
  localparam logic [SUBW-1:0] SA_DEV_LO = 8'h02;
  localparam logic [SUBW-1:0] SA_DEV_HI = 8'h03;
  localparam logic [SUBW-1:0] SA_REV    = 8'h04;
  localparam logic [SUBW-1:0] SA_FMIN   = 8'h06;
  localparam logic [SUBW-1:0] SA_FMAX   = 8'h07;
  localparam logic [SUBW-1:0] SA_MODE   = 8'h08;
  localparam logic [SUBW-1:0] SA_MON    = 8'h09;
  localparam logic [SUBW-1:0] SA_SKEW   = 8'h0A;
  localparam logic [SUBW-1:0] SA_CFG    = 8'h0B;
  localparam logic [SUBW-1:0] SA_TUNE   = 8'h0C;
  typedef enum logic [2:0] {PH_IDLE, PH_DEV, PH_SUB, PH_WDAT, PH_RDAT, PH_SKIP} phase_t;
endpackage

// File: rtl/dvi_line_sync.sv
module dvi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] pipe_q, pipe_d;
  logic prev_q;

  always_comb begin
    pipe_d = {pipe_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= pipe_d;
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign dout = pipe_q[STAGES-1];
  assign rise = dout & ~prev_q;
  assign fall = ~dout & prev_q;
endmodule

// File: rtl/dvi_byte_engine.sv
module dvi_byte_engine
  import dvi_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl,
  input  logic            sda,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            sda_rise,
  input  logic            sda_fall,
  input  logic [2:0]      dev_pins,
  input  logic [7:0]      rd_data,
  output logic [SUBW-1:0] sub_addr,
  output logic            wr_stb,
  output logic [7:0]      wr_data,
  output logic            sda_oe
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_SLOT = 4'd8;

  phase_t          phase_q, phase_d;
  logic [3:0]      cnt_q, cnt_d;
  logic [7:0]      shf_q, shf_d;
  logic [7:0]      tx_q, tx_d;
  logic [SUBW-1:0] ptr_q, ptr_d;
  logic            ack_q, ack_d;
  logic            oe_q, oe_d;
  logic            stb_q, stb_d;
  logic            start_ev, stop_ev, active;

  assign start_ev = scl & sda_fall;
  assign stop_ev  = scl & sda_rise;
  assign active   = (phase_q != PH_IDLE) && (phase_q != PH_SKIP);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    shf_d   = shf_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    ack_d   = ack_q;
    oe_d    = oe_q;
    stb_d   = 1'b0;
    if (start_ev) begin
      phase_d = PH_DEV;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (stop_ev) begin
      phase_d = PH_IDLE;
      cnt_d   = '0;
      ack_d   = 1'b0;
      oe_d    = 1'b0;
    end else if (scl_rise && active) begin
      if (cnt_q != ACK_SLOT) begin
        shf_d = {shf_q[6:0], sda};
        cnt_d = cnt_q + 4'd1;
        if (cnt_q == LAST_BIT) begin
          if (phase_q == PH_DEV) ack_d = (shf_q[6:0] == {DEV_PREFIX, dev_pins});
          else                   ack_d = (phase_q != PH_RDAT);
        end
      end else begin
        cnt_d = '0;
        ack_d = 1'b0;
        unique case (phase_q)
          PH_DEV: begin
            if (!ack_q) phase_d = PH_SKIP;
            else if (shf_q[0]) begin
              phase_d = PH_RDAT;
              tx_d    = rd_data;
            end else phase_d = PH_SUB;
          end
          PH_SUB: begin
            ptr_d   = shf_q;
            phase_d = PH_WDAT;
          end
          PH_WDAT: begin
            stb_d   = 1'b1;
            phase_d = PH_SKIP;
          end
          default: phase_d = PH_SKIP;
        endcase
      end
    end else if (scl_fall) begin
      if (phase_q == PH_RDAT) oe_d = (cnt_q != ACK_SLOT) && !tx_q[~cnt_q[2:0]];
      else                    oe_d = (cnt_q == ACK_SLOT) && ack_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ack_q   <= 1'b0;
      oe_q    <= 1'b0;
      stb_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      ack_q   <= ack_d;
      oe_q    <= oe_d;
      stb_q   <= stb_d;
    end
  end

  always_ff @(posedge clk) begin
    shf_q <= shf_d;
    tx_q  <= tx_d;
    ptr_q <= ptr_d;
  end

  assign sub_addr = ptr_q;
  assign wr_stb   = stb_q;
  assign wr_data  = shf_q;
  assign sda_oe   = oe_q;
endmodule

// File: rtl/dvi_cfg_regfile.sv
module dvi_cfg_regfile
  import dvi_cfg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  logic [SUBW-1:0] addr,
  input  logic [7:0]      wr_data,
  output logic [7:0]      rd_data,
  input  logic            hot_plug,
  input  logic            rx_sense,
  input  logic            vref_low,
  input  logic [2:0]      gp_in,
  input  logic [7:0]      cfg_in,
  output logic            pwr_on,
  output logic [4:0]      mode_bits,
  output logic [2:0]      mon_sel,
  output logic [2:0]      dsk_step,
  output logic            dsk_en,
  output logic [7:0]      tune_byte
);
  logic       pwr_q;
  logic [2:0] msel_q;
  logic [4:0] mode_q;
  logic [2:0] dsk_q;
  logic       dsken_q;
  logic [7:0] tune_q;
  logic       we_mode, we_mon, we_skew, we_tune;

  assign we_mode = wr_stb && (addr == SA_MODE);
  assign we_mon  = wr_stb && (addr == SA_MON);
  assign we_skew = wr_stb && (addr == SA_SKEW);
  assign we_tune = wr_stb && (addr == SA_TUNE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_q  <= 1'b0;
      msel_q <= '0;
    end else begin
      if (we_mode) pwr_q  <= wr_data[0];
      if (we_mon)  msel_q <= wr_data[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (we_mode) mode_q <= wr_data[5:1];
    if (we_skew) begin
      dsk_q   <= wr_data[2:0];
      dsken_q <= wr_data[3];
    end
    if (we_tune) tune_q <= wr_data;
  end

  always_comb begin
    unique case (addr)
      SA_VEN_LO: rd_data = 8'h01;
      SA_DEV_LO: rd_data = 8'h06;
      SA_FMIN:   rd_data = 8'h19;
      SA_FMAX:   rd_data = 8'h64;
      SA_MODE:   rd_data = {2'b00, mode_q, pwr_q};
      SA_MON:    rd_data = {1'b0, vref_low, rx_sense, hot_plug, 1'b0, msel_q};
      SA_SKEW:   rd_data = {1'b0, gp_in, dsken_q, dsk_q};
      SA_CFG:    rd_data = cfg_in;
      SA_TUNE:   rd_data = tune_q;
      default:   rd_data = 8'h00;
    endcase
  end

  assign pwr_on    = pwr_q;
  assign mode_bits = mode_q;
  assign mon_sel   = msel_q;
  assign dsk_step  = dsk_q;
  assign dsk_en    = dsken_q;
  assign tune_byte = tune_q;
endmodule

// File: rtl/dvi_cfg_regs.sv
module dvi_cfg_regs
  import dvi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_pins,
  input  logic       hot_plug,
  input  logic       rx_sense,
  input  logic       vref_low,
  input  logic [2:0] gp_in,
  input  logic [7:0] cfg_in,
  output logic       pwr_on,
  output logic       edge_rise,
  output logic       wide_bus,
  output logic       dual_edge,
  output logic       hs_en,
  output logic       vs_en,
  output logic [2:0] mon_sel,
  output logic [2:0] dsk_step,
  output logic       dsk_en,
  output logic [7:0] tune_byte
);
  logic [1:0]      rst_pipe_q;
  logic            srst_n;
  logic            scl_s, scl_r, scl_f;
  logic            sda_s, sda_r, sda_f;
  logic [SUBW-1:0] sub_addr;
  logic            wr_stb;
  logic [7:0]      wr_data, rd_data;
  logic [4:0]      mode_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  dvi_line_sync #(.STAGES(SYNC_STAGES)) scl_sync_i (
    .clk(clk), .rst_n(srst_n), .din(scl_i), .dout(scl_s), .rise(scl_r), .fall(scl_f));
  dvi_line_sync #(.STAGES(SYNC_STAGES)) sda_sync_i (
    .clk(clk), .rst_n(srst_n), .din(sda_i), .dout(sda_s), .rise(sda_r), .fall(sda_f));

  dvi_byte_engine eng_i (
    .clk(clk), .rst_n(srst_n), .scl(scl_s), .sda(sda_s),
    .scl_rise(scl_r), .scl_fall(scl_f), .sda_rise(sda_r), .sda_fall(sda_f),
    .dev_pins(dev_pins), .rd_data(rd_data), .sub_addr(sub_addr),
    .wr_stb(wr_stb), .wr_data(wr_data), .sda_oe(sda_oe));

  dvi_cfg_regfile regs_i (
    .clk(clk), .rst_n(srst_n), .wr_stb(wr_stb), .addr(sub_addr),
    .wr_data(wr_data), .rd_data(rd_data),
    .hot_plug(hot_plug), .rx_sense(rx_sense), .vref_low(vref_low),
    .gp_in(gp_in), .cfg_in(cfg_in),
    .pwr_on(pwr_on), .mode_bits(mode_bits), .mon_sel(mon_sel),
    .dsk_step(dsk_step), .dsk_en(dsk_en), .tune_byte(tune_byte));

  assign edge_rise = mode_bits[0];
  assign wide_bus  = mode_bits[1];
  assign dual_edge = mode_bits[2];
  assign hs_en     = mode_bits[3];
  assign vs_en     = mode_bits[4];
endmodule

// File: rtl/dvi_cfg_chk.sv
module dvi_cfg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_lvl,
  input logic       sda_oe,
  input logic       wr_stb,
  input logic [7:0] wr_addr,
  input logic       pwr_on,
  input logic [2:0] mon_sel,
  input logic [7:0] tune
);
  // R2
  rst_pwr_chk: assert property (@(posedge clk) !rst_n |-> !pwr_on);
  // R2
  rst_msel_chk: assert property (@(posedge clk) !rst_n |-> (mon_sel == 3'b000));
  // R9
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);
  // R10
  pwr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwr_on) |-> $past(wr_stb && (wr_addr == 8'h08)));
  // R3
  tune_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(tune) |-> $past(wr_stb && (wr_addr == 8'h0C)));
endmodule

bind dvi_cfg_regs dvi_cfg_chk chk_i (
  .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .sda_oe(sda_oe),
  .wr_stb(wr_stb), .wr_addr(sub_addr), .pwr_on(pwr_on),
  .mon_sel(mon_sel), .tune(tune_byte));

// File: tb/dvi_cfg_regs_tb.sv
module dvi_cfg_regs_tb_top;
  localparam int Q = 6;
  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic sda_oe, sda_bus;
  logic [2:0] dev_pins;
  logic hot_plug, rx_sense, vref_low;
  logic [2:0] gp_in;
  logic [7:0] cfg_in;
  logic pwr_on, edge_rise, wide_bus, dual_edge, hs_en, vs_en, dsk_en;
  logic [2:0] mon_sel, dsk_step;
  logic [7:0] tune_byte;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit quiet = 0;
  bit known = 0;

  // reference model state
  bit       m_pwr;
  bit [4:0] m_mode;
  bit [2:0] m_msel, m_dsk;
  bit       m_dsken;
  bit [7:0] m_tune;

  always #4ns clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  dvi_cfg_regs dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_pins(dev_pins), .hot_plug(hot_plug), .rx_sense(rx_sense),
    .vref_low(vref_low), .gp_in(gp_in), .cfg_in(cfg_in),
    .pwr_on(pwr_on), .edge_rise(edge_rise), .wide_bus(wide_bus),
    .dual_edge(dual_edge), .hs_en(hs_en), .vs_en(vs_en), .mon_sel(mon_sel),
    .dsk_step(dsk_step), .dsk_en(dsk_en), .tune_byte(tune_byte));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit [7:0] exp_read(bit [7:0] a);
    case (a)
      8'h00: return 8'h01;
      8'h02: return 8'h06;
      8'h06: return 8'h19;
      8'h07: return 8'h64;
      8'h08: return {2'b00, m_mode, m_pwr};
      8'h09: return {1'b0, vref_low, rx_sense, hot_plug, 1'b0, m_msel};
      8'h0A: return {1'b0, gp_in, m_dsken, m_dsk};
      8'h0B: return cfg_in;
      8'h0C: return m_tune;
      default: return 8'h00;
    endcase
  endfunction

  function automatic void model_write(bit [7:0] a, bit [7:0] d);
    case (a)
      8'h08: begin m_pwr = d[0]; m_mode = d[5:1]; end
      8'h09: m_msel = d[2:0];
      8'h0A: begin m_dsk = d[2:0]; m_dsken = d[3]; end
      8'h0C: m_tune = d;
      default: ;
    endcase
  endfunction

  // per-clock comparison of outputs against the model while the bus is quiet
  always @(negedge clk) begin
    if (!done) begin
      cyc++;
      if (quiet && rst_n) begin
        chk("R10 pwr_on", pwr_on, m_pwr);
        chk("R10 mon_sel", mon_sel, m_msel);
        chk("R10 sda_oe idle", sda_oe, 0);
        if (known) begin
          chk("R10 mode", {vs_en, hs_en, dual_edge, wide_bus, edge_rise}, m_mode);
          chk("R10 skew", {dsk_en, dsk_step}, {m_dsken, m_dsk});
          chk("R10 tune", tune_byte, m_tune);
        end
      end
      if (cyc > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  // R9: slave drive may only move while SCL is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !done && (sda_oe !== oe_prev)) chk("R9 scl at sda change", scl_m, 0);
    oe_prev <= sda_oe;
  end

  task automatic wc(int n); repeat (n) @(negedge clk); endtask

  task automatic bit_out(bit b);
    sda_m = b; wc(Q); scl_m = 1; wc(2*Q); scl_m = 0; wc(Q);
  endtask

  task automatic bit_in(output bit b);
    sda_m = 1; wc(Q); scl_m = 1; wc(Q); b = sda_bus; wc(Q); scl_m = 0; wc(Q);
  endtask

  task automatic bus_start();
    quiet = 0;
    sda_m = 1; wc(Q); scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; wc(Q); scl_m = 1; wc(Q); sda_m = 1; wc(2*Q);
    wc(4); quiet = 1;
  endtask

  task automatic send_byte(bit [7:0] v, output bit acked);
    bit a;
    for (int i = 7; i >= 0; i--) bit_out(v[i]);
    bit_in(a);
    acked = !a;
  endtask

  task automatic recv_byte(output bit [7:0] v, input bit mack);
    for (int i = 7; i >= 0; i--) bit_in(v[i]);
    bit_out(!mack);
  endtask

  function automatic bit [6:0] dev_of(bit [2:0] p);
    return {4'b0111, p};
  endfunction

  task automatic wr_txn(bit [6:0] dev, bit [7:0] sub, bit [7:0] dat,
                        output bit a_dev, output bit a_sub, output bit a_dat);
    bus_start();
    send_byte({dev, 1'b0}, a_dev);
    send_byte(sub, a_sub);
    send_byte(dat, a_dat);
    bus_stop();
  endtask

  task automatic rd_txn(bit [6:0] dev, bit [7:0] sub, output bit [7:0] d, output bit a_dev);
    bit a1, a2;
    bus_start();
    send_byte({dev, 1'b0}, a_dev);
    send_byte(sub, a1);
    sda_m = 1; wc(Q); scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
    send_byte({dev, 1'b1}, a2);
    recv_byte(d, 1'b0);
    bus_stop();
  endtask

  task automatic good_write(string req, bit [7:0] sub, bit [7:0] dat);
    bit a0, a1, a2;
    wr_txn(dev_of(dev_pins), sub, dat, a0, a1, a2);
    model_write(sub, dat);
    chk({req, " ack"}, {a0, a1, a2}, 3'b111);
  endtask

  task automatic read_chk(string req, bit [7:0] sub);
    bit [7:0] d;
    bit a;
    rd_txn(dev_of(dev_pins), sub, d, a);
    chk({req, " addr ack"}, a, 1);
    chk(req, d, exp_read(sub));
  endtask

  task automatic pulse_reset();
    quiet = 0;
    rst_n = 0;
    wc(5);
    m_pwr = 0;
    m_msel = 0;
    chk("R2 pwr_on in reset", pwr_on, 0);
    chk("R2 mon_sel in reset", mon_sel, 0);
    rst_n = 1;
    wc(4);
    quiet = 1;
  endtask

  initial begin
    bit a0, a1, a2, a3;
    bit [7:0] d;
    rst_n = 1; scl_m = 1; sda_m = 1;
    dev_pins = 3'b000; hot_plug = 0; rx_sense = 0; vref_low = 0;
    gp_in = 3'b000; cfg_in = 8'h00;
    #1ns;
    pulse_reset();
    chk("R2 sda_oe after reset", sda_oe, 0);

    // R4 identity and frequency limits
    read_chk("R4 ven lo", 8'h00);
    read_chk("R4 ven hi", 8'h01);
    read_chk("R4 dev lo", 8'h02);
    read_chk("R4 dev hi", 8'h03);
    read_chk("R4 rev", 8'h04);
    read_chk("R4 fmin", 8'h06);
    read_chk("R4 fmax", 8'h07);

    // R5 writes of every field
    good_write("R5 mode", 8'h08, 8'h3F);
    good_write("R5 mon", 8'h09, 8'h05);
    good_write("R5 skew", 8'h0A, 8'h0D);
    good_write("R5 tune", 8'h0C, 8'h89);
    known = 1;
    chk("R5 pwr_on", pwr_on, 1);
    chk("R5 tune_byte", tune_byte, 8'h89);
    read_chk("R6 mode readback", 8'h08);
    good_write("R5 mode pattern", 8'h08, 8'h2A);
    chk("R5 fields 2A", {vs_en, hs_en, dual_edge, wide_bus, edge_rise, pwr_on}, 6'h2A);

    // R6 status inputs
    hot_plug = 1; rx_sense = 0; vref_low = 1; gp_in = 3'b101; cfg_in = 8'hA5;
    read_chk("R6 mon status", 8'h09);
    read_chk("R6 skew status", 8'h0A);
    read_chk("R6 cfg byte", 8'h0B);
    hot_plug = 0; rx_sense = 1; vref_low = 0; gp_in = 3'b010; cfg_in = 8'h3C;
    read_chk("R6 mon status 2", 8'h09);
    read_chk("R6 cfg byte 2", 8'h0B);

    // R1 address mismatch and strap change
    wr_txn(dev_of(3'b001), 8'h08, 8'h15, a0, a1, a2);
    chk("R1 wrong addr nack", {a0, a1, a2}, 3'b000);
    read_chk("R1 mode unchanged", 8'h08);
    dev_pins = 3'b101;
    wr_txn(dev_of(3'b000), 8'h0C, 8'h00, a0, a1, a2);
    chk("R1 old addr nack", a0, 0);
    good_write("R1 new addr", 8'h09, 8'h02);
    read_chk("R1 new addr read", 8'h09);

    // R8 read-only and unmapped
    good_write("R8 ro write", 8'h02, 8'h55);
    read_chk("R8 ro unchanged", 8'h02);
    good_write("R8 unmapped write", 8'h30, 8'hFF);
    read_chk("R8 unmapped read", 8'h30);

    // R7 extra write byte
    bus_start();
    send_byte({dev_of(dev_pins), 1'b0}, a0);
    send_byte(8'h0C, a1);
    send_byte(8'h11, a2);
    send_byte(8'h22, a3);
    bus_stop();
    model_write(8'h0C, 8'h11);
    chk("R7 first data ack", {a0, a1, a2}, 3'b111);
    chk("R7 second data nack", a3, 0);
    chk("R7 tune first only", tune_byte, 8'h11);

    // R7 extra read clocks
    bus_start();
    send_byte({dev_of(dev_pins), 1'b0}, a0);
    send_byte(8'h06, a1);
    sda_m = 1; wc(Q); scl_m = 1; wc(Q); sda_m = 0; wc(Q); scl_m = 0; wc(Q);
    send_byte({dev_of(dev_pins), 1'b1}, a2);
    recv_byte(d, 1'b1);
    chk("R7 first read byte", d, 8'h19);
    recv_byte(d, 1'b0);
    chk("R7 second read released", d, 8'hFF);
    bus_stop();

    // R3 retention through reset
    good_write("R3 pre mode", 8'h08, 8'h35);
    good_write("R3 pre tune", 8'h0C, 8'h89);
    pulse_reset();
    chk("R3 pwr cleared", pwr_on, 0);
    chk("R3 mode kept", {vs_en, hs_en, dual_edge, wide_bus, edge_rise}, 5'h1A);
    chk("R3 tune kept", tune_byte, 8'h89);
    chk("R3 skew kept", {dsk_en, dsk_step}, 4'hD);
    read_chk("R3 skew read", 8'h0A);
    read_chk("R3 mode read", 8'h08);
    good_write("R5 power up again", 8'h08, 8'h01);
    chk("R5 pwr_on after reset write", pwr_on, 1);

    wc(10);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule